// File: doc/BRIEF.md
# Buffered-Tuning Phase Accumulator

This block is the phase engine of a numerically controlled oscillator. On every clock it adds an active tuning word to an n-bit accumulator, wrapping modulo 2^n, so the output frequency is the tuning word times the clock rate divided by 2^n. The smallest frequency step is therefore the clock rate over 2^n. A phase-offset word is added to the running phase, and only the top bits of that sum go on to a later phase-to-amplitude stage. The dropped low bits stay in the accumulator, so truncation costs no frequency resolution.

A new tuning word never goes straight into the active register. It is first collected in a holding buffer. The buffer can be filled one bit per clock, most significant bit first, or one byte per clock at a chosen lane. A single commit strobe then copies the whole buffer into the active register on one clock edge. The accumulator keeps running through loading and commit, so the frequency changes on the next clock without any jump in phase. A full serial load takes n clocks and a byte load takes n/8 clocks. That load time limits how often the frequency can be retuned.

Top module: `nco_phase_core`

## Requirements
- R1: A synchronous reset clears the accumulator, the holding buffer and the active tuning word. After reset the accumulator reads 0 and the wrap flag reads 0. A commit with no load between it and the reset yields a step of 0.
- R2: On each clock edge outside reset, the accumulator becomes its old value plus the active tuning word, modulo 2^ACC_W.
- R3: The wrap flag is high for the one cycle after an addition that carried out of bit ACC_W-1, and low otherwise.
- R4: While ser_en is high, the buffer shifts left by one bit per clock and takes ser_bit into bit 0. After ACC_W such clocks, the first bit shifted in sits at bit ACC_W-1.
- R5: A byte write with ser_en low replaces buffer bits [8*i+7:8*i], where i is byte_idx. All other buffer bits are left as they were. An index of ACC_W/8 or more writes nothing. When ser_en is high, byte writes are ignored.
- R6: A commit copies the buffer, as it stood before that edge, into the active tuning word on that edge. The accumulator keeps the old step on the commit edge and uses the new step from the next edge onward. The accumulator is not reset or moved.
- R7: A commit during a partly finished serial load copies the partial buffer exactly as it stands. Its value is the bits shifted in since reset, read as a right-aligned binary number.
- R8: phase_out equals the top PHASE_W bits of (accumulator + phase_off) modulo 2^ACC_W. The offset never changes the accumulator.
- R9: Loading the buffer, serially or by bytes, has no effect on the accumulator's step until a commit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| ser_en | input | 1 | Shift ser_bit into the buffer this clock |
| ser_bit | input | 1 | Serial tuning bit, MSB first |
| byte_we | input | 1 | Write byte_data into one buffer lane |
| byte_idx | input | IDX_W | Buffer lane index (lane 0 = bits 7:0) |
| byte_data | input | 8 | Byte written to the selected lane |
| commit | input | 1 | Copy the buffer into the active tuning word |
| phase_off | input | ACC_W | Phase offset added before truncation |
| acc_out | output | ACC_W | Full accumulator value |
| phase_out | output | PHASE_W | Truncated, offset phase |
| wrap | output | 1 | One-cycle carry-out flag |

## Verification
The bench first targets the commit edge. A design that applied the new word on the commit edge itself would be off by the difference of the two steps. A design that cleared the accumulator on commit would lose all prior phase.

It then commits after only four serial bits. A buffer that latched its value only after a full word, or that shifted LSB first, would give a different step.

It also writes one byte lane over a serially loaded word. Lane decoding that is wrong or spills over would corrupt the neighbouring bytes.

Finally, it drives a near-full-scale word and a half-scale word to force carries. A wrap flag tied to the wrong bit, or held longer than one cycle, shows up there. So does an offset that leaks into the accumulator.

// File: rtl/nco_pkg.sv
package nco_pkg;

   localparam int unsigned LANE_W = 8;

   // Lanes needed to hold a word of the given width
   function automatic int unsigned lane_count(input int unsigned width);
      return (width + LANE_W - 1) / LANE_W;
   endfunction

   // Index width for a lane count (at least one bit)
   function automatic int unsigned idx_width(input int unsigned lanes);
      return (lanes > 1) ? $clog2(lanes) : 1;
   endfunction

endpackage

// File: rtl/nco_tune_buffer.sv
module nco_tune_buffer
   import nco_pkg::*;
#(
   parameter int unsigned ACC_W = 32,
   localparam int unsigned NLANES = lane_count(ACC_W),
   localparam int unsigned IDX_W  = idx_width(NLANES)
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             ser_en,
   input  logic             ser_bit,
   input  logic             byte_we,
   input  logic [IDX_W-1:0] byte_idx,
   input  logic [7:0]       byte_data,
   output logic [ACC_W-1:0] buf_q
);

   logic [ACC_W-1:0] buf_d;

   always_comb begin
      buf_d = buf_q;
      if (ser_en) begin
         buf_d = {buf_q[ACC_W-2:0], ser_bit};
      end else if (byte_we) begin
         for (int b = 0; b < int'(NLANES); b++) begin
            if (byte_idx == IDX_W'(b)) begin
               buf_d[b*LANE_W +: LANE_W] = byte_data;
            end
         end
      end
   end

   always_ff @(posedge clk) begin
      if (rst) buf_q <= '0;
      else     buf_q <= buf_d;
   end

endmodule

// File: rtl/nco_tune_active.sv
module nco_tune_active #(
   parameter int unsigned ACC_W = 32
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             commit,
   input  logic [ACC_W-1:0] buf_q,
   output logic [ACC_W-1:0] step_q
);

   always_ff @(posedge clk) begin
      if (rst)         step_q <= '0;
      else if (commit) step_q <= buf_q;
   end

endmodule

// File: rtl/nco_accum.sv
module nco_accum #(
   parameter int unsigned ACC_W = 32
) (
   input  logic             clk,
   input  logic             rst,
   input  logic [ACC_W-1:0] step_q,
   output logic [ACC_W-1:0] acc_q,
   output logic             carry_q
);

   logic [ACC_W:0] sum_w;

   assign sum_w = {1'b0, acc_q} + {1'b0, step_q};

   always_ff @(posedge clk) begin
      if (rst) begin
         acc_q   <= '0;
         carry_q <= 1'b0;
      end else begin
         acc_q   <= sum_w[ACC_W-1:0];
         carry_q <= sum_w[ACC_W];
      end
   end

endmodule

// File: rtl/nco_phase_trunc.sv
module nco_phase_trunc #(
   parameter int unsigned ACC_W      = 32,
   parameter int unsigned PHASE_W    = 14,
   parameter bit          HAS_OFFSET = 1'b1
) (
   input  logic [ACC_W-1:0]   acc_q,
   input  logic [ACC_W-1:0]   phase_off,
   output logic [PHASE_W-1:0] phase_out
);

   logic [ACC_W-1:0] shifted;

   generate
      if (HAS_OFFSET) begin : g_off
         assign shifted = acc_q + phase_off;
      end else begin : g_nooff
         logic unused_off;
         assign unused_off = ^phase_off;
         assign shifted = acc_q;
      end

      if (PHASE_W == ACC_W) begin : g_full
         assign phase_out = shifted;
      end else begin : g_cut
         logic unused_low;
         assign unused_low = ^shifted[ACC_W-PHASE_W-1:0];
         assign phase_out  = shifted[ACC_W-1 -: PHASE_W];
      end
   endgenerate

endmodule

// File: rtl/nco_phase_core.sv
module nco_phase_core
   import nco_pkg::*;
#(
   parameter int unsigned ACC_W      = 32,
   parameter int unsigned PHASE_W    = 14,
   parameter bit          HAS_OFFSET = 1'b1,
   localparam int unsigned NLANES    = lane_count(ACC_W),
   localparam int unsigned IDX_W     = idx_width(NLANES)
) (
   input  logic               clk,
   input  logic               rst,
   input  logic               ser_en,
   input  logic               ser_bit,
   input  logic               byte_we,
   input  logic [IDX_W-1:0]   byte_idx,
   input  logic [7:0]         byte_data,
   input  logic               commit,
   input  logic [ACC_W-1:0]   phase_off,
   output logic [ACC_W-1:0]   acc_out,
   output logic [PHASE_W-1:0] phase_out,
   output logic               wrap
);

   generate
      if (ACC_W < 24 || ACC_W > 48) begin : g_bad_acc
         $error("ACC_W must lie between 24 and 48");
      end
      if (ACC_W % LANE_W != 0) begin : g_bad_lane
         $error("ACC_W must be a whole number of bytes");
      end
      if (PHASE_W < 1 || PHASE_W > ACC_W) begin : g_bad_phase
         $error("PHASE_W must be between 1 and ACC_W");
      end
   endgenerate

   logic [ACC_W-1:0] tune_buf;
   logic [ACC_W-1:0] tune_active;

   nco_tune_buffer #(.ACC_W(ACC_W)) u_buf (
      .clk       (clk),
      .rst       (rst),
      .ser_en    (ser_en),
      .ser_bit   (ser_bit),
      .byte_we   (byte_we),
      .byte_idx  (byte_idx),
      .byte_data (byte_data),
      .buf_q     (tune_buf)
   );

   nco_tune_active #(.ACC_W(ACC_W)) u_act (
      .clk    (clk),
      .rst    (rst),
      .commit (commit),
      .buf_q  (tune_buf),
      .step_q (tune_active)
   );

   nco_accum #(.ACC_W(ACC_W)) u_acc (
      .clk     (clk),
      .rst     (rst),
      .step_q  (tune_active),
      .acc_q   (acc_out),
      .carry_q (wrap)
   );

   nco_phase_trunc #(
      .ACC_W      (ACC_W),
      .PHASE_W    (PHASE_W),
      .HAS_OFFSET (HAS_OFFSET)
   ) u_trunc (
      .acc_q     (acc_out),
      .phase_off (phase_off),
      .phase_out (phase_out)
   );

endmodule

// File: rtl/nco_phase_core_chk.sv
module nco_phase_core_chk #(
   parameter int unsigned ACC_W = 32
) (
   input logic             clk,
   input logic             rst,
   input logic             commit,
   input logic [ACC_W-1:0] acc_out,
   input logic             wrap,
   input logic [ACC_W-1:0] active_q,
   input logic [ACC_W-1:0] buffer_q
);

   // High when the previous edge was a non-reset edge
   logic past_ok;
   always_ff @(posedge clk) begin
      if (rst) past_ok <= 1'b0;
      else     past_ok <= 1'b1;
   end

   assert_reset_clear_R1 : assert property (@(posedge clk)
      rst |=> (acc_out == '0 && !wrap && active_q == '0 && buffer_q == '0));

   assert_acc_step_R2 : assert property (@(posedge clk) disable iff (rst)
      past_ok |-> acc_out == ACC_W'($past(acc_out) + $past(active_q)));

   assert_wrap_carry_R3 : assert property (@(posedge clk) disable iff (rst)
      past_ok |-> wrap == (acc_out < $past(acc_out)));

   assert_commit_copy_R6 : assert property (@(posedge clk) disable iff (rst)
      commit |=> active_q == $past(buffer_q));

   assert_hold_active_R9 : assert property (@(posedge clk) disable iff (rst)
      (past_ok && !commit) |=> $stable(active_q));

endmodule

bind nco_phase_core nco_phase_core_chk #(.ACC_W(ACC_W)) u_chk (
   .clk      (clk),
   .rst      (rst),
   .commit   (commit),
   .acc_out  (acc_out),
   .wrap     (wrap),
   .active_q (tune_active),
   .buffer_q (tune_buf)
);

// File: tb/sim_nco_phase_core.sv
module sim_nco_phase_core;

   localparam int CLK_PERIOD = 10;
   localparam int ACC_W   = 32;
   localparam int PHASE_W = 14;

   typedef struct packed {
      logic        by_byte;
      logic [31:0] word;
      logic [7:0]  run;
      logic [31:0] off;
      logic [31:0] exp_acc;
      logic [13:0] exp_ph;
   } vec_t;

   localparam vec_t VECS [6] = '{
      '{1'b0, 32'h0000_0001, 8'd5, 32'h0,          32'h0000_0005, 14'h0000},
      '{1'b1, 32'h0004_0000, 8'd3, 32'h0,          32'h000C_0000, 14'h0003},
      '{1'b0, 32'h8000_0000, 8'd3, 32'h0,          32'h8000_0000, 14'h2000},
      '{1'b1, 32'hFFFF_FFFF, 8'd2, 32'h3,          32'hFFFF_FFFE, 14'h0000},
      '{1'b0, 32'h1234_5678, 8'd1, 32'h4000_0000,  32'h1234_5678, 14'h148D},
      '{1'b1, 32'h4000_0000, 8'd4, 32'h0,          32'h0000_0000, 14'h0000}
   };

   logic               clk = 1'b0;
   logic               rst = 1'b1;
   logic               ser_en = 1'b0;
   logic               ser_bit = 1'b0;
   logic               byte_we = 1'b0;
   logic [1:0]         byte_idx = '0;
   logic [7:0]         byte_data = '0;
   logic               commit = 1'b0;
   logic [ACC_W-1:0]   phase_off = '0;
   logic [ACC_W-1:0]   acc_out;
   logic [PHASE_W-1:0] phase_out;
   logic               wrap;

   int checks = 0;
   int failures = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   nco_phase_core #(.ACC_W(ACC_W), .PHASE_W(PHASE_W)) u0 (
      .clk(clk), .rst(rst), .ser_en(ser_en), .ser_bit(ser_bit),
      .byte_we(byte_we), .byte_idx(byte_idx), .byte_data(byte_data),
      .commit(commit), .phase_off(phase_off),
      .acc_out(acc_out), .phase_out(phase_out), .wrap(wrap)
   );

   task automatic step();
      @(negedge clk);
   endtask

   task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic do_reset();
      rst = 1'b1;
      step();
      rst = 1'b0;
   endtask

   task automatic load_serial(input logic [31:0] w);
      for (int i = ACC_W - 1; i >= 0; i--) begin
         ser_en = 1'b1;
         ser_bit = w[i];
         step();
      end
      ser_en = 1'b0;
   endtask

   task automatic load_bytes(input logic [31:0] w);
      for (int i = 0; i < ACC_W / 8; i++) begin
         byte_we = 1'b1;
         byte_idx = 2'(i);
         byte_data = w[i*8 +: 8];
         step();
      end
      byte_we = 1'b0;
   endtask

   task automatic do_commit();
      commit = 1'b1;
      step();
      commit = 1'b0;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      failures++;
      checks++;
      $display("FAIL watchdog actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      step();
      do_reset();
      // R1: reset state
      check("R1 acc", 64'(acc_out), 64'h0);
      check("R1 wrap", 64'(wrap), 64'h0);
      // R1: cleared buffer commits a zero step
      do_commit();
      step(); step(); step();
      check("R1 zero step", 64'(acc_out), 64'h0);

      // Table walk: R2 step, R4 serial, R5 byte load, R8 offset/truncation
      for (int v = 0; v < 6; v++) begin
         do_reset();
         if (VECS[v].by_byte) load_bytes(VECS[v].word);
         else                 load_serial(VECS[v].word);
         do_commit();
         phase_off = VECS[v].off;
         for (int k = 0; k < int'(VECS[v].run); k++) step();
         check("R2/R4/R5 acc", 64'(acc_out), 64'(VECS[v].exp_acc));
         check("R8 phase", 64'(phase_out), 64'(VECS[v].exp_ph));
         phase_off = '0;
      end

      // R3: wrap flag on half-scale step
      do_reset();
      load_serial(32'h8000_0000);
      do_commit();
      step();
      check("R3 no wrap", 64'(wrap), 64'h0);
      step();
      check("R3 wrap acc", 64'(acc_out), 64'h0);
      check("R3 wrap high", 64'(wrap), 64'h1);
      step();
      check("R3 wrap one cycle", 64'(wrap), 64'h0);

      // R9: loading does not disturb the running step
      do_reset();
      load_serial(32'h0000_0001);
      do_commit();
      for (int k = 0; k < 10; k++) step();
      check("R2 run", 64'(acc_out), 64'd10);
      phase_off = 32'h1000_0000;
      load_serial(32'hFFFF_FFFF);
      check("R9 acc during load", 64'(acc_out), 64'd42);
      // R8: offset leaves acc alone, shows in phase
      check("R8 phase offset", 64'(phase_out), 64'h400);
      // R6: commit edge still uses old step, then new step with no jump
      do_commit();
      check("R6 commit edge", 64'(acc_out), 64'd43);
      step();
      check("R6 new step", 64'(acc_out), 64'd42);
      check("R3 carry", 64'(wrap), 64'h1);
      phase_off = '0;

      // R7: commit after four serial bits 1,0,1,1
      do_reset();
      ser_en = 1'b1;
      ser_bit = 1'b1; step();
      ser_bit = 1'b0; step();
      ser_bit = 1'b1; step();
      ser_bit = 1'b1; step();
      ser_en = 1'b0;
      do_commit();
      step(); step();
      check("R7 partial", 64'(acc_out), 64'd22);

      // R5: one lane overwritten, others kept
      do_reset();
      load_serial(32'h1122_3344);
      byte_we = 1'b1; byte_idx = 2'd2; byte_data = 8'hAB;
      step();
      byte_we = 1'b0;
      do_commit();
      step();
      check("R5 lane", 64'(acc_out), 64'h11AB_3344);

      // R5: byte write ignored while shifting
      do_reset();
      ser_en = 1'b1; ser_bit = 1'b1;
      byte_we = 1'b1; byte_idx = 2'd3; byte_data = 8'hFF;
      step();
      ser_en = 1'b0; byte_we = 1'b0;
      do_commit();
      step();
      check("R5 serial priority", 64'(acc_out), 64'd1);

      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule